// File: doc/BRIEF.md
# Grouped Interrupt Priority Controller

This block arbitrates five interrupt sources for a small 8-bit processor core. Three sources are external pins. Each pin passes through a synchronizer and an edge detector, and the edges that count can be chosen. The other two sources are single-cycle event pulses from a 16-bit timer and an 8-bit timer. Every detected event sets a bit in a request register. A mask register holds one enable bit per source and a master enable.

An arbiter picks the winning unmasked request. The six request slots (IRQ0 to IRQ5) form three pairs, called groups. A 3-bit code sets the order of the three groups. One bit per group sets which member of that pair wins. The block drives a pending flag and the index of the winning slot. When the core acknowledges, only that slot's request bit is cleared.

The core reaches the three registers through a small bus with one address for both read and write. The address codes are 0 for the priority register, 1 for the request register and 2 for the mask register. Address 3 is unused.

Top module: `irq_prio_ctl`

## Requirements
- R1: Sources map as follows. Pin 0 feeds IRQ0, pin 1 feeds IRQ1 and pin 2 feeds IRQ2. The 16-bit timer pulse feeds IRQ3 and the 8-bit timer pulse feeds IRQ4. A pin change is latched in the request register on the third rising clock edge after the change. A timer pulse is latched on the next edge.
- R2: Request register bits [7:6] choose the active pin edges. 00 selects falling on pin 2 and falling on pin 0. 01 selects falling on pin 2 and rising on pin 0. 10 selects rising on pin 2 and falling on pin 0. 11 selects both edges on both pins.
- R3: Pin 1 sets IRQ1 only on a falling edge, whatever the edge-select bits hold.
- R4: After reset, the request register and the mask register read 0 and irq_pend is 0.
- R5: Mask bits [4:0] enable IRQ4..IRQ0, with bit 0 for IRQ0. Mask bit 7 is the master enable. irq_pend is 1 only when the master enable is 1 and some request is both set and enabled.
- R6: Priority register bits [2:0] set the group order. Group A is {IRQ3, IRQ5}, group B is {IRQ0, IRQ2} and group C is {IRQ1, IRQ4}. The codes are 001 C>A>B, 010 A>B>C, 011 A>C>B, 100 B>C>A, 101 C>B>A and 110 B>A>C.
- R7: Priority bit 3 orders group C: 0 means IRQ1 wins over IRQ4, 1 means IRQ4 wins. Bit 4 orders group B: 0 means IRQ2 wins over IRQ0, 1 means IRQ0 wins. Bit 5 orders group A: 0 means IRQ5 wins over IRQ3, 1 means IRQ3 wins.
- R8: Group codes 000 and 111 are reserved. While either is set, no interrupt is granted and irq_pend stays 0.
- R9: Writing 1 to a request bit [4:0] sets it. A request set by software is arbitrated exactly like one set by hardware.
- R10: A cycle with irq_ack=1 and irq_pend=1 clears the request bit of the slot at irq_idx and leaves every other request bit unchanged.
- R11: IRQ5 has no source. Its request bit (bit 5) always reads 0 and slot 5 is never granted.
- R12: The priority register is write-only. Reads at address 0 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 2 | Register address: 0 priority, 1 request, 2 mask |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| ext_pin | input | 3 | Asynchronous external request pins |
| tmr16_evt | input | 1 | 16-bit timer event pulse |
| tmr8_evt | input | 1 | 8-bit timer event pulse |
| irq_ack | input | 1 | Acknowledge of the granted interrupt |
| irq_pend | output | 1 | An enabled request is pending |
| irq_idx | output | 3 | Index of the winning slot |

## Verification
Some rules are checked by assertions in every cycle. A grant needs the master enable. The granted slot must be active. Slot 5 is never granted. A reserved code never grants. Every source event lands in the request register. An acknowledge clears only the granted bit. Other behaviour can only be shown by the bench's scenarios. These are the full order for each group code, the effect of each in-group bit, the pin edge choice under each edge-select value, the falling-only rule of pin 1, the exact latency of the synchronizer, and the write-only readback of the priority register.

// File: rtl/irq_prio_pkg.sv
package irq_prio_pkg;
  localparam int NSRC  = 5;
  localparam int NSLOT = 6;
  localparam int NPIN  = 3;
  localparam int IDXW  = $clog2(NSLOT);

  typedef enum logic [1:0] {GRP_A = 2'd0, GRP_B = 2'd1, GRP_C = 2'd2} grp_e;

  typedef struct packed {
    logic ok;
    grp_e first;
    grp_e second;
    grp_e third;
  } grp_order_t;

  typedef logic [NSLOT-1:0][IDXW-1:0] slot_list_t;

  function automatic grp_order_t decode_order(input logic [2:0] code);
    grp_order_t o;
    o = '{ok: 1'b1, first: GRP_A, second: GRP_B, third: GRP_C};
    case (code)
      3'b001: begin o.first = GRP_C; o.second = GRP_A; o.third = GRP_B; end
      3'b010: begin o.first = GRP_A; o.second = GRP_B; o.third = GRP_C; end
      3'b011: begin o.first = GRP_A; o.second = GRP_C; o.third = GRP_B; end
      3'b100: begin o.first = GRP_B; o.second = GRP_C; o.third = GRP_A; end
      3'b101: begin o.first = GRP_C; o.second = GRP_B; o.third = GRP_A; end
      3'b110: begin o.first = GRP_B; o.second = GRP_A; o.third = GRP_C; end
      default: o.ok = 1'b0;
    endcase
    return o;
  endfunction

  function automatic logic [IDXW-1:0] pair_lead(input grp_e g, input logic flip);
    case (g)
      GRP_A:   return flip ? IDXW'(3) : IDXW'(5);
      GRP_B:   return flip ? IDXW'(0) : IDXW'(2);
      default: return flip ? IDXW'(4) : IDXW'(1);
    endcase
  endfunction

  function automatic logic [IDXW-1:0] pair_trail(input grp_e g, input logic flip);
    return pair_lead(g, ~flip);
  endfunction

  function automatic slot_list_t slot_list(input grp_order_t o, input logic [2:0] flips);
    slot_list_t l;
    l[0] = pair_lead (o.first,  flips[o.first]);
    l[1] = pair_trail(o.first,  flips[o.first]);
    l[2] = pair_lead (o.second, flips[o.second]);
    l[3] = pair_trail(o.second, flips[o.second]);
    l[4] = pair_lead (o.third,  flips[o.third]);
    l[5] = pair_trail(o.third,  flips[o.third]);
    return l;
  endfunction

  function automatic logic [2*NPIN-1:0] edge_enables(input logic [1:0] mode);
    logic [2*NPIN-1:0] e;
    e = '0;
    e[2*0+0] = (mode != 2'b01);
    e[2*0+1] = mode[0];
    e[2*1+0] = 1'b1;
    e[2*1+1] = 1'b0;
    e[2*2+0] = (mode != 2'b10);
    e[2*2+1] = mode[1];
    return e;
  endfunction
endpackage

// File: rtl/irq_pin_sync.sv
module irq_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b1;
    else        chain[0] <= pin;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[s] <= 1'b1;
      else        chain[s] <= chain[s-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev <= 1'b1;
    else        prev <= chain[STAGES-1];
  end

  assign rise = chain[STAGES-1] & ~prev;
  assign fall = ~chain[STAGES-1] & prev;
endmodule

// File: rtl/irq_reg_bank.sv
module irq_reg_bank
  import irq_prio_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            bus_wr,
  input  logic [1:0]      bus_addr,
  input  logic [7:0]      bus_wdata,
  output logic [7:0]      bus_rdata,
  input  logic [NSRC-1:0] hw_set,
  input  logic [NSRC-1:0] ack_clr,
  output logic [5:0]      prio_q,
  output logic [NSRC-1:0] req_q,
  output logic [1:0]      edge_q,
  output logic [NSRC-1:0] en_q,
  output logic            master_q,
  output logic            req_wr
);
  localparam logic [1:0] A_PRIO = 2'd0;
  localparam logic [1:0] A_REQ  = 2'd1;
  localparam logic [1:0] A_MASK = 2'd2;

  logic [NSRC-1:0] req_nx;

  assign req_wr = bus_wr && (bus_addr == A_REQ);

  always_comb begin
    req_nx = req_wr ? bus_wdata[NSRC-1:0] : req_q;
    req_nx = (req_nx & ~ack_clr) | hw_set;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prio_q   <= '0;
      req_q    <= '0;
      edge_q   <= '0;
      en_q     <= '0;
      master_q <= 1'b0;
    end else begin
      req_q <= req_nx;
      if (req_wr) edge_q <= bus_wdata[7:6];
      if (bus_wr && bus_addr == A_PRIO) prio_q <= bus_wdata[5:0];
      if (bus_wr && bus_addr == A_MASK) begin
        en_q     <= bus_wdata[NSRC-1:0];
        master_q <= bus_wdata[7];
      end
    end
  end

  always_comb begin
    case (bus_addr)
      A_REQ:   bus_rdata = {edge_q, 1'b0, req_q};
      A_MASK:  bus_rdata = {master_q, 2'b00, en_q};
      default: bus_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/irq_prio_sel.sv
module irq_prio_sel
  import irq_prio_pkg::*;
(
  input  logic [NSLOT-1:0] act,
  input  logic [2:0]       code,
  input  logic [2:0]       flips,
  output logic             pend,
  output logic [IDXW-1:0]  idx
);
  grp_order_t ord;
  slot_list_t lst;

  always_comb begin
    ord  = decode_order(code);
    lst  = slot_list(ord, flips);
    pend = 1'b0;
    idx  = '0;
    if (ord.ok) begin
      for (int i = 0; i < NSLOT; i++) begin
        if (!pend && act[lst[i]]) begin
          pend = 1'b1;
          idx  = lst[i];
        end
      end
    end
  end
endmodule

// File: rtl/irq_prio_ctl.sv
module irq_prio_ctl
  import irq_prio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr,
  input  logic [1:0]  bus_addr,
  input  logic [7:0]  bus_wdata,
  output logic [7:0]  bus_rdata,
  input  logic [2:0]  ext_pin,
  input  logic        tmr16_evt,
  input  logic        tmr8_evt,
  input  logic        irq_ack,
  output logic        irq_pend,
  output logic [2:0]  irq_idx
);
  logic [NPIN-1:0]   pin_rise, pin_fall, pin_evt;
  logic [2*NPIN-1:0] edge_en;
  logic [NSRC-1:0]   hw_set, ack_clr, req_q, en_q;
  logic [5:0]        prio_q;
  logic [1:0]        edge_q;
  logic              master_q, req_wr;
  logic [NSLOT-1:0]  act;
  logic [2:0]        flips;
  logic [NSLOT-1:0]  grant_oh;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    irq_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk (clk),
      .rst_n (rst_n),
      .pin (ext_pin[p]),
      .rise (pin_rise[p]),
      .fall (pin_fall[p])
    );
    assign pin_evt[p] = (pin_rise[p] & edge_en[2*p+1]) | (pin_fall[p] & edge_en[2*p]);
  end

  assign edge_en = edge_enables(edge_q);
  assign hw_set  = {tmr8_evt, tmr16_evt, pin_evt};

  irq_reg_bank u_regs (
    .clk (clk),
    .rst_n (rst_n),
    .bus_wr (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .hw_set (hw_set),
    .ack_clr (ack_clr),
    .prio_q (prio_q),
    .req_q (req_q),
    .edge_q (edge_q),
    .en_q (en_q),
    .master_q (master_q),
    .req_wr (req_wr)
  );

  assign act   = {1'b0, req_q & en_q & {NSRC{master_q}}};
  assign flips = {prio_q[3], prio_q[4], prio_q[5]};

  irq_prio_sel u_sel (
    .act (act),
    .code (prio_q[2:0]),
    .flips (flips),
    .pend (irq_pend),
    .idx (irq_idx)
  );

  assign grant_oh = NSLOT'(1) << irq_idx;
  assign ack_clr  = (irq_ack && irq_pend) ? grant_oh[NSRC-1:0] : '0;
endmodule

// File: rtl/irq_prio_chk.sv
module irq_prio_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       pend,
  input logic [2:0] idx,
  input logic       master,
  input logic [5:0] act,
  input logic [4:0] req,
  input logic [4:0] hw_set,
  input logic       ack,
  input logic       req_wr,
  input logic [2:0] code
);
  logic [5:0] req6, set6;
  assign req6 = {1'b0, req};
  assign set6 = {1'b0, hw_set};

  p_master_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> master);

  p_grant_active_r6: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> act[idx]);

  p_no_slot5_r11: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> (idx != 3'd5));

  p_reserved_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (code == 3'b000 || code == 3'b111) |-> !pend);

  p_event_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_set) |=> ((req & $past(hw_set)) == $past(hw_set)));

  p_ack_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && pend && !req_wr && !set6[idx]) |=> !req6[$past(idx)]);

  p_ack_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && pend && !req_wr) |=>
      ((req6 & ($past(req6) & ~(6'd1 << $past(idx)))) == ($past(req6) & ~(6'd1 << $past(idx)))));
endmodule

bind irq_prio_ctl irq_prio_chk u_chk (
  .clk (clk),
  .rst_n (rst_n),
  .pend (irq_pend),
  .idx (irq_idx),
  .master (master_q),
  .act (act),
  .req (req_q),
  .hw_set (hw_set),
  .ack (irq_ack),
  .req_wr (req_wr),
  .code (prio_q[2:0])
);

// File: tb/sim_irq_prio_ctl.sv
`timescale 1ns/1ps
module sim_irq_prio_ctl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_wr = 1'b0;
  logic [1:0] bus_addr = 2'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic [2:0] ext_pin = 3'b111;
  logic       tmr16_evt = 1'b0, tmr8_evt = 1'b0, irq_ack = 1'b0;
  logic       irq_pend;
  logic [2:0] irq_idx;
  int         n_run = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  irq_prio_ctl u0 (.*);

  // {prio, mask, req, exp_pend, exp_idx}
  localparam int NV = 14;
  localparam logic [24:0] VEC [NV] = '{
    {8'h03, 8'h9F, 5'h1F, 1'b1, 3'd3},   // R6 A>C>B, R7 A default picks IRQ3 since IRQ5 empty
    {8'h03, 8'h9F, 5'h07, 1'b1, 3'd1},   // R7 C default IRQ1
    {8'h0B, 8'h9F, 5'h17, 1'b1, 3'd4},   // R7 C flipped IRQ4
    {8'h04, 8'h9F, 5'h1F, 1'b1, 3'd2},   // R6 B>C>A, B default IRQ2
    {8'h14, 8'h9F, 5'h1F, 1'b1, 3'd0},   // R7 B flipped IRQ0
    {8'h05, 8'h9F, 5'h0D, 1'b1, 3'd2},   // R6 C>B>A
    {8'h06, 8'h9F, 5'h1A, 1'b1, 3'd3},   // R6 B>A>C
    {8'h01, 8'h9F, 5'h09, 1'b1, 3'd3},   // R6 C>A>B
    {8'h02, 8'h9F, 5'h12, 1'b1, 3'd1},   // R6 A>B>C
    {8'h07, 8'h9F, 5'h1F, 1'b0, 3'd0},   // R8 code 111
    {8'h00, 8'h9F, 5'h1F, 1'b0, 3'd0},   // R8 code 000
    {8'h03, 8'h1F, 5'h1F, 1'b0, 3'd0},   // R5 master off
    {8'h03, 8'h86, 5'h19, 1'b0, 3'd0},   // R5 all set bits masked
    {8'h05, 8'h91, 5'h1F, 1'b1, 3'd4}    // R5 IRQ1 masked, C picks IRQ4
  };

  task automatic check(input logic ok, input string tag, input int act_v, input int exp_v);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act_v, exp_v);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic pin_case(input int p, input logic lvl, input logic [1:0] mode,
                          input logic exp, input string tag);
    logic [7:0] d;
    wr(2'd1, {mode, 6'b0});
    ext_pin[p] = lvl;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rd(2'd1, d);
    check(d[p] == exp, tag, d[p], exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R4 reset state
    rd(2'd1, d); check(d == 8'h00, "R4 request reset", d, 0);
    rd(2'd2, d); check(d == 8'h00, "R4 mask reset", d, 0);
    check(irq_pend == 1'b0, "R4 pend reset", irq_pend, 0);

    // vector table: R5 R6 R7 R8
    for (int i = 0; i < NV; i++) begin
      wr(2'd0, VEC[i][24:17]);
      wr(2'd2, VEC[i][16:9]);
      wr(2'd1, {3'b000, VEC[i][8:4]});
      check(irq_pend == VEC[i][3], $sformatf("R6 vec%0d pend", i), irq_pend, VEC[i][3]);
      if (VEC[i][3])
        check(irq_idx == VEC[i][2:0], $sformatf("R7 vec%0d idx", i), irq_idx, VEC[i][2:0]);
    end

    // R12 write-only priority
    wr(2'd0, 8'h23);
    rd(2'd0, d); check(d == 8'h00, "R12 priority read", d, 0);

    // R11 slot 5 empty: group A favors IRQ5 by default
    wr(2'd2, 8'hBF);
    wr(2'd1, 8'h3F);
    rd(2'd1, d); check(d == 8'h1F, "R11 bit5 readback", d, 8'h1F);
    wr(2'd0, 8'h03);
    check(irq_pend && irq_idx == 3'd3, "R11 no slot5 grant", irq_idx, 3);

    // R9 software set behaves like hardware
    wr(2'd1, 8'h00);
    check(irq_pend == 1'b0, "R9 cleared", irq_pend, 0);
    wr(2'd0, 8'h04);
    wr(2'd1, 8'h04);
    check(irq_pend && irq_idx == 3'd2, "R9 software grant", irq_idx, 2);

    // R10 ack clears only granted bit
    wr(2'd1, 8'h1F);
    check(irq_idx == 3'd2, "R10 before ack", irq_idx, 2);
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
    rd(2'd1, d); check(d == 8'h1B, "R10 ack clear", d, 8'h1B);
    check(irq_pend && irq_idx == 3'd0, "R10 next winner", irq_idx, 0);

    // R1 timer sources
    wr(2'd1, 8'h00);
    @(negedge clk); tmr16_evt = 1'b1;
    @(negedge clk); tmr16_evt = 1'b0;
    rd(2'd1, d); check(d == 8'h08, "R1 timer16 to IRQ3", d, 8'h08);
    wr(2'd1, 8'h00);
    @(negedge clk); tmr8_evt = 1'b1;
    @(negedge clk); tmr8_evt = 1'b0;
    rd(2'd1, d); check(d == 8'h10, "R1 timer8 to IRQ4", d, 8'h10);

    // R1 latency: not yet set after two edges
    wr(2'd1, 8'h00);
    ext_pin[0] = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rd(2'd1, d); check(d[0] == 1'b0, "R1 latency early", d[0], 0);
    @(negedge clk);
    rd(2'd1, d); check(d[0] == 1'b1, "R1 latency third edge", d[0], 1);
    ext_pin[0] = 1'b1;
    repeat (4) @(negedge clk);

    // R2 edge selection
    pin_case(0, 1'b0, 2'b00, 1'b1, "R2 m00 p0 fall");
    pin_case(0, 1'b1, 2'b00, 1'b0, "R2 m00 p0 rise");
    pin_case(2, 1'b0, 2'b00, 1'b1, "R2 m00 p2 fall");
    pin_case(2, 1'b1, 2'b00, 1'b0, "R2 m00 p2 rise");
    pin_case(0, 1'b0, 2'b01, 1'b0, "R2 m01 p0 fall");
    pin_case(0, 1'b1, 2'b01, 1'b1, "R2 m01 p0 rise");
    pin_case(2, 1'b0, 2'b01, 1'b1, "R2 m01 p2 fall");
    pin_case(2, 1'b1, 2'b01, 1'b0, "R2 m01 p2 rise");
    pin_case(0, 1'b0, 2'b10, 1'b1, "R2 m10 p0 fall");
    pin_case(0, 1'b1, 2'b10, 1'b0, "R2 m10 p0 rise");
    pin_case(2, 1'b0, 2'b10, 1'b0, "R2 m10 p2 fall");
    pin_case(2, 1'b1, 2'b10, 1'b1, "R2 m10 p2 rise");
    pin_case(0, 1'b0, 2'b11, 1'b1, "R2 m11 p0 fall");
    pin_case(0, 1'b1, 2'b11, 1'b1, "R2 m11 p0 rise");
    pin_case(2, 1'b0, 2'b11, 1'b1, "R2 m11 p2 fall");
    pin_case(2, 1'b1, 2'b11, 1'b1, "R2 m11 p2 rise");
    // R3 pin 1 falling only
    pin_case(1, 1'b0, 2'b00, 1'b1, "R3 m00 p1 fall");
    pin_case(1, 1'b1, 2'b00, 1'b0, "R3 m00 p1 rise");
    pin_case(1, 1'b0, 2'b11, 1'b1, "R3 m11 p1 fall");
    pin_case(1, 1'b1, 2'b11, 1'b0, "R3 m11 p1 rise");

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule